// File: doc/BRIEF.md
# SIMD Lane Shift, Rotate and Shuffle Unit

This unit operates on a 64-bit packed operand. It can treat the operand as four 16-bit lanes, two 32-bit lanes or one 64-bit lane. In that lane view it performs logical right shift, logical left shift, arithmetic right shift and rotate right, and no lane ever leaks bits into a neighbour. It also has two permutation modes that ignore the lane view. One is a four-way halfword shuffle steered by an 8-bit selector. The other is a byte-granular extraction of 64 bits from the pair formed by two operands.

An operation is issued by raising `in_valid` together with its operands. The result appears one cycle later on a registered output, and `out_valid` marks that cycle. Shift, rotate and shuffle results also refresh a packed status word. This word holds a negative bit and a zero bit for each lane of the result, at positions that depend on the lane size. Align leaves the status word untouched, so a reader still sees the flags of the last lane operation.

Top module: `simd_perm_unit`

## Requirements
- R1: `result` and `nz_flags` are registered. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `result` and `nz_flags` hold their values.
- R2: `op` codes are 0 logical right, 1 logical left, 2 arithmetic right, 3 rotate right, 4 shuffle and 5 align. `lane_sz` selects 16-bit lanes (0), 32-bit lanes (1) or one 64-bit lane (2 or 3). Shifts act on each lane separately, and bits shifted out of a lane are discarded.
- R3: A logical shift whose count (`amt`, unsigned) is equal to or greater than the lane width gives an all-zero lane.
- R4: Arithmetic right shift fills vacated bits with the lane's sign bit. A count equal to or greater than the lane width fills the whole lane with the sign bit.
- R5: Rotate right uses the count modulo the lane width. Bits leaving the bottom of a lane re-enter at its top, and a reduced count of zero returns the lane unchanged.
- R6: In shuffle, destination halfword k (bits 16k+15..16k) is the source halfword whose index is `amt[2k+1:2k]`. `lane_sz` has no effect on shuffle.
- R7: Align takes n = `amt[2:0]` and returns the low 64 bits of {`opnd_b`,`opnd_a`} shifted right by 8n bits. `amt[7:3]` and `lane_sz` have no effect on align.
- R8: After shift, rotate or shuffle, the status word is rewritten from the result. For 16-bit lane i the N bit (lane MSB) is bit 8i+7 and the Z bit (lane all zero) is bit 8i+6. For 32-bit lane i these are bits 16i+15 and 16i+14. For the 64-bit lane they are bits 31 and 30. All other bits are 0, and shuffle uses the 16-bit layout.
- R9: Align and the unused codes 6 and 7 leave `nz_flags` unchanged. Codes 6 and 7 give a zero result.
- R10: Reset (synchronous, active high) clears `out_valid`, `result` and `nz_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| op | input | 3 | Operation code |
| lane_sz | input | 2 | Lane size select for shift and rotate |
| opnd_a | input | 64 | Main operand |
| opnd_b | input | 64 | Upper operand for align |
| amt | input | 8 | Shift or rotate count, shuffle selector, or align byte offset |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 64 | Registered result |
| nz_flags | output | 32 | Packed per-lane negative and zero flags |

## Verification
Two actions share the output register: capturing a new result and refreshing the status word. An align therefore writes `result` in a cycle in which `nz_flags` must keep whatever the previous lane operation left there. The bench provokes this with back-to-back issues, placing a shift or shuffle immediately before an align and before an unused code. It then compares both outputs against a model that carries the flag word from one operation to the next. Random streams with idle gaps also place these pairs next to each other in many lane sizes.

// File: rtl/simd_perm_pkg.sv
package simd_perm_pkg;

  typedef enum logic [2:0] {
    OP_SRL   = 3'd0,
    OP_SLL   = 3'd1,
    OP_SRA   = 3'd2,
    OP_ROR   = 3'd3,
    OP_SHUF  = 3'd4,
    OP_ALIGN = 3'd5
  } perm_op_e;

  typedef enum logic [1:0] {
    LANE_16 = 2'd0,
    LANE_32 = 2'd1,
    LANE_64 = 2'd2
  } lane_sz_e;

endpackage

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     din,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       kind,
  output logic [W-1:0]     dout
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] sh;
  logic          over;

  assign sh   = cnt[SW-1:0];
  assign over = (32'(cnt) >= W);

  always_comb begin
    case (kind)
      2'd0: dout = over ? '0 : (din >> sh);
      2'd1: dout = over ? '0 : (din << sh);
      2'd2: dout = over ? {W{din[W-1]}} : W'($signed(din) >>> sh);
      default: begin
        if (sh == '0) dout = din;
        else          dout = (din >> sh) | (din << (W - 32'(sh)));
      end
    endcase
  end
endmodule

// File: rtl/simd_hw_shuffle.sv
module simd_hw_shuffle #(
  parameter int HW = 16
) (
  input  logic [4*HW-1:0] din,
  input  logic [7:0]      sel,
  output logic [4*HW-1:0] dout
);
  for (genvar k = 0; k < 4; k++) begin : g_dst
    logic [1:0] idx;
    assign idx = sel[2*k +: 2];
    assign dout[k*HW +: HW] = din[idx*HW +: HW];
  end
endmodule

// File: rtl/simd_byte_align.sv
module simd_byte_align #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [2:0]        nbytes,
  output logic [DATA_W-1:0] dout
);
  logic [2*DATA_W-1:0] cat;
  assign cat  = {hi, lo} >> {nbytes, 3'b000};
  assign dout = cat[DATA_W-1:0];
endmodule

// File: rtl/simd_nz_pack.sv
module simd_nz_pack #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   res,
  input  logic [1:0]          sz,
  output logic [DATA_W/2-1:0] fl
);
  localparam int HW     = DATA_W / 4;
  localparam int WW     = DATA_W / 2;
  localparam int FLAG_W = DATA_W / 2;

  logic [FLAG_W-1:0] fh, fw, fd;

  always_comb begin
    fh = '0;
    fw = '0;
    fd = '0;
    for (int i = 0; i < 4; i++) begin
      fh[(FLAG_W/4)*i + FLAG_W/4 - 1] = res[HW*i + HW - 1];
      fh[(FLAG_W/4)*i + FLAG_W/4 - 2] = (res[HW*i +: HW] == '0);
    end
    for (int i = 0; i < 2; i++) begin
      fw[(FLAG_W/2)*i + FLAG_W/2 - 1] = res[WW*i + WW - 1];
      fw[(FLAG_W/2)*i + FLAG_W/2 - 2] = (res[WW*i +: WW] == '0);
    end
    fd[FLAG_W-1] = res[DATA_W-1];
    fd[FLAG_W-2] = (res == '0);
  end

  always_comb begin
    case (sz)
      2'd0:    fl = fh;
      2'd1:    fl = fw;
      default: fl = fd;
    endcase
  end
endmodule

// File: rtl/simd_perm_unit.sv
module simd_perm_unit
  import simd_perm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [1:0]          lane_sz,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic [CNT_W-1:0]    amt,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/2-1:0] nz_flags
);
  localparam int HW     = DATA_W / 4;
  localparam int WW     = DATA_W / 2;
  localparam int FLAG_W = DATA_W / 2;

  logic [DATA_W-1:0] sh_h, sh_w, sh_d, shuf_res, align_res, next_res;
  logic [FLAG_W-1:0] next_fl;
  logic [1:0]        flag_sz;
  logic              upd_flags;

  for (genvar i = 0; i < DATA_W / HW; i++) begin : g_h
    simd_lane_shift #(.W(HW), .CNT_W(CNT_W)) u_sh (
      .din(opnd_a[i*HW +: HW]), .cnt(amt), .kind(op[1:0]), .dout(sh_h[i*HW +: HW]));
  end
  for (genvar i = 0; i < DATA_W / WW; i++) begin : g_w
    simd_lane_shift #(.W(WW), .CNT_W(CNT_W)) u_sh (
      .din(opnd_a[i*WW +: WW]), .cnt(amt), .kind(op[1:0]), .dout(sh_w[i*WW +: WW]));
  end
  simd_lane_shift #(.W(DATA_W), .CNT_W(CNT_W)) u_sh_d (
    .din(opnd_a), .cnt(amt), .kind(op[1:0]), .dout(sh_d));

  simd_hw_shuffle #(.HW(HW)) u_shuf (
    .din(opnd_a), .sel(amt[7:0]), .dout(shuf_res));

  simd_byte_align #(.DATA_W(DATA_W)) u_align (
    .lo(opnd_a), .hi(opnd_b), .nbytes(amt[2:0]), .dout(align_res));

  always_comb begin
    next_res  = '0;
    upd_flags = 1'b0;
    flag_sz   = LANE_16;
    case (op)
      OP_SRL, OP_SLL, OP_SRA, OP_ROR: begin
        upd_flags = 1'b1;
        case (lane_sz)
          LANE_16: begin next_res = sh_h; flag_sz = LANE_16; end
          LANE_32: begin next_res = sh_w; flag_sz = LANE_32; end
          default: begin next_res = sh_d; flag_sz = LANE_64; end
        endcase
      end
      OP_SHUF: begin
        upd_flags = 1'b1;
        next_res  = shuf_res;
      end
      OP_ALIGN: next_res = align_res;
      default:  next_res = '0;
    endcase
  end

  simd_nz_pack #(.DATA_W(DATA_W)) u_nz (
    .res(next_res), .sz(flag_sz), .fl(next_fl));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      nz_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        if (upd_flags) nz_flags <= next_fl;
      end
    end
  end
endmodule

// File: rtl/simd_perm_unit_chk.sv
module simd_perm_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          op,
  input logic [1:0]          lane_sz,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [DATA_W-1:0]   opnd_b,
  input logic [CNT_W-1:0]    amt,
  input logic                out_valid,
  input logic [DATA_W-1:0]   result,
  input logic [DATA_W/2-1:0] nz_flags
);
  localparam int FLAG_W = DATA_W / 2;

  function automatic logic [FLAG_W-1:0] used_bits();
    logic [FLAG_W-1:0] m = '0;
    for (int i = 0; i < FLAG_W / 8; i++) begin
      m[8*i+7] = 1'b1;
      m[8*i+6] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [FLAG_W-1:0] USED = used_bits();

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(nz_flags)));
  p_big_srl_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && 32'(amt) >= DATA_W) |=> (result == '0));
  p_ror_zero_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3 && amt == '0) |=> (result == $past(opnd_a)));
  p_align_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5) |=> $stable(nz_flags));
  p_unused_op_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b11) |=> (result == '0 && $stable(nz_flags)));
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ((nz_flags & ~USED) == '0));
  p_n_z_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    ((nz_flags & (nz_flags >> 1) & (USED >> 1) & USED) == '0));
endmodule

bind simd_perm_unit simd_perm_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .amt(amt), .out_valid(out_valid),
  .result(result), .nz_flags(nz_flags));

// File: tb/tb_simd_perm_unit.sv
`timescale 1ns/1ps
module tb_simd_perm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  amt = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] nz_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        ev = 1'b0;
  logic [63:0] er = '0;
  logic [31:0] ef = '0;

  always #4 clk = ~clk;

  simd_perm_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .amt(amt), .out_valid(out_valid),
    .result(result), .nz_flags(nz_flags));

  function automatic int lane_w(input logic [2:0] o, input logic [1:0] s);
    if (o == 3'd4) return 16;
    if (s == 2'd0) return 16;
    if (s == 2'd1) return 32;
    return 64;
  endfunction

  function automatic logic [63:0] ref_lane(input logic [2:0] o, input int w,
                                           input logic [63:0] x0, input int n);
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] x = x0 & m;
    logic        sgn = x[w-1];
    int          r;
    case (o)
      3'd0: return (n >= w) ? 64'd0 : (x >> n);
      3'd1: return (n >= w) ? 64'd0 : ((x << n) & m);
      3'd2: begin
        if (n >= w) return sgn ? m : 64'd0;
        return (x >> n) | (sgn ? (m & ~(m >> n)) : 64'd0);
      end
      default: begin
        r = n % w;
        if (r == 0) return x;
        return ((x >> r) | (x << (w - r))) & m;
      end
    endcase
  endfunction

  function automatic logic [63:0] ref_result(input logic [2:0] o, input logic [1:0] s,
      input logic [63:0] a, input logic [63:0] b, input logic [7:0] n);
    logic [63:0] out = '0;
    int w, k8;
    if (o <= 3'd3) begin
      w = lane_w(o, s);
      for (int i = 0; i < 64 / w; i++)
        out |= ref_lane(o, w, a >> (i * w), int'(n)) << (i * w);
    end else if (o == 3'd4) begin
      for (int k = 0; k < 4; k++)
        out |= ((a >> (16 * int'((n >> (2 * k)) & 8'd3))) & 64'hFFFF) << (16 * k);
    end else if (o == 3'd5) begin
      k8 = 8 * int'(n[2:0]);
      out = (k8 == 0) ? a : ((a >> k8) | (b << (64 - k8)));
    end
    return out;
  endfunction

  function automatic logic [31:0] ref_flags(input logic [31:0] prev, input logic [2:0] o,
      input logic [1:0] s, input logic [63:0] r);
    logic [31:0] f = '0;
    logic [63:0] lane, m;
    int w;
    if (o >= 3'd5) return prev;
    w = lane_w(o, s);
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < 64 / w; i++) begin
      lane = (r >> (i * w)) & m;
      f[(w / 2) * i + w / 2 - 1] = lane[w-1];
      f[(w / 2) * i + w / 2 - 2] = (lane == 64'd0);
    end
    return f;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (out_valid !== ev || result !== er || nz_flags !== ef) begin
      fails++;
      $display("FAIL %s: valid %0b exp %0b, result %h exp %h, flags %h exp %h",
               tag, out_valid, ev, result, er, nz_flags, ef);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] n, input string tag);
    in_valid = v; op = o; lane_sz = s; opnd_a = a; opnd_b = b; amt = n;
    ev = v;
    if (v) begin
      er = ref_result(o, s, a, b, n);
      ef = ref_flags(ef, o, s, er);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state");

    // R2 lane-confined shifts
    issue(1, 3'd0, 2'd0, 64'h8001_F00F_1234_FFFF, '0, 8'd4, "R2 srl halfword");
    issue(1, 3'd1, 2'd1, 64'hFF00_00FF_8000_0001, '0, 8'd8, "R2 sll word");
    issue(1, 3'd1, 2'd2, 64'h0123_4567_89AB_CDEF, '0, 8'd12, "R2 sll dword");
    issue(1, 3'd0, 2'd3, 64'h8000_0000_0000_0000, '0, 8'd63, "R2 srl size code 3");
    // R3 counts at or above width
    issue(1, 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd16, "R3 srl halfword count 16");
    issue(1, 3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd200, "R3 sll word count 200");
    issue(1, 3'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd64, "R3 sll dword count 64");
    // R4 arithmetic right
    issue(1, 3'd2, 2'd0, 64'h8000_7FFF_F0F0_0F0F, '0, 8'd3, "R4 sra halfword");
    issue(1, 3'd2, 2'd0, 64'h8000_7FFF_F0F0_0F0F, '0, 8'd20, "R4 sra halfword over");
    issue(1, 3'd2, 2'd1, 64'h8765_4321_1234_5678, '0, 8'd31, "R4 sra word 31");
    issue(1, 3'd2, 2'd2, 64'hC000_0000_0000_0001, '0, 8'd255, "R4 sra dword 255");
    // R5 rotate
    issue(1, 3'd3, 2'd0, 64'h1234_5678_9ABC_DEF0, '0, 8'd0, "R5 ror zero");
    issue(1, 3'd3, 2'd0, 64'h0001_8000_0003_1234, '0, 8'd17, "R5 ror halfword 17");
    issue(1, 3'd3, 2'd1, 64'h0000_0001_8000_0000, '0, 8'd32, "R5 ror word 32");
    issue(1, 3'd3, 2'd2, 64'h0000_0000_0000_000F, '0, 8'd68, "R5 ror dword 68");
    // R6 shuffle
    issue(1, 3'd4, 2'd1, 64'h4444_3333_2222_1111, '0, 8'h1B, "R6 shuffle reverse");
    issue(1, 3'd4, 2'd2, 64'h4444_3333_2222_8111, '0, 8'h00, "R6 shuffle broadcast");
    issue(1, 3'd4, 2'd0, 64'h0000_FFFF_0000_1234, '0, 8'hE4, "R6 shuffle identity");
    // R9 align right after a flag update
    issue(1, 3'd7, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, '1, 8'd5, "R9 unused code 7");
    issue(1, 3'd5, 2'd0, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'd0, "R7 align n0");
    issue(1, 3'd5, 2'd1, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'd3, "R7 align n3");
    issue(1, 3'd5, 2'd2, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'hFB, "R7 align upper bits ignored");
    issue(1, 3'd5, 2'd0, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'd7, "R7 align n7");
    issue(1, 3'd0, 2'd1, '0, '0, 8'd1, "R8 zero word flags");
    issue(1, 3'd5, 2'd0, 64'h8000_0000_0000_0000, '1, 8'd1, "R9 align keeps flags");
    issue(1, 3'd6, 2'd1, 64'h1, '0, 8'd0, "R9 unused code 6");
    issue(1, 3'd2, 2'd2, 64'h8000_0000_0000_0000, '0, 8'd0, "R8 dword negative");
    // R1 hold while idle
    issue(0, 3'd0, 2'd0, 64'h1234, '0, 8'd1, "R1 idle hold");
    issue(0, 3'd4, 2'd0, 64'h5678, '0, 8'd9, "R1 idle hold second");
    issue(1, 3'd4, 2'd0, 64'h0000_8000_0000_0001, '0, 8'h27, "R8 shuffle flags");

    for (int i = 0; i < 600; i++) begin
      logic [7:0] n;
      n = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 70);
      issue(($urandom % 5) != 0, 3'($urandom), 2'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, n, "R2 random mix");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule